// File: doc/BRIEF.md
# ADC Conversion Scheduler with Auto-Delay

This block decides when an analog-to-digital converter core may begin its next conversion. It serves two groups: a regular group that converts one channel per start, and a higher-priority injected group that converts a programmable sequence of one to four channels back to back. Each group can be started by a hardware trigger or a software start request. The analog converter is modelled here as a fixed latency of `CONV_CYCLES` clocks after each start.

With auto-delay enabled, the scheduler lets the reader set the pace. After each regular result the regular group holds off until the data register is read or the end-of-conversion flag is cleared. After the last conversion of an injected sequence the injected group holds off until its end-of-sequence flag is cleared. A hardware trigger that arrives during its group's hold-off is discarded. A software start still forces a conversion. The holds of the two groups are independent, except in auto-injected mode, where each regular result launches the injected sequence by itself and the next regular conversion also waits for the injected end-of-sequence flag to clear.

Each regular result raises a one-cycle DMA request. In circular mode the requests never stop. In one-shot mode they stop once a programmed count is reached. The count restarts whenever DMA is disabled.

Top module: `adc_sched`

## Requirements
- R1: After reset, convStart, eocFlag, jeosFlag, ovrFlag and dmaReq are all 0, and no conversion starts without a trigger or start request.
- R2: A regular start is announced by a one-cycle convStart with convGroup=0 and convChan=0. Once the conversion completes, eocFlag reads 1.
- R3: An injected sequence runs cfgInjLen+1 conversions back to back, with convGroup=1 and convChan counting 0,1,..,cfgInjLen. jeosFlag is set only after the last of them. Every new sequence restarts at channel 0.
- R4: If a regular and an injected request are both pending while idle, the injected sequence runs first and the regular conversion follows it.
- R5: With cfgAutoDelay=1 and eocFlag=1, a regular hardware trigger is dropped. It does not start a conversion, neither then nor after the result is later consumed.
- R6: A regular hold-off ends when drRead or clrEoc is pulsed (either one clears eocFlag). A regular hardware trigger after that starts a conversion.
- R7: With cfgAutoDelay=1 and jeosFlag=1, an injected hardware trigger is dropped. After clrJeos, an injected trigger is accepted.
- R8: A software start request for a group starts a conversion even while that group is held off.
- R9: An injected trigger during a regular hold-off starts the injected sequence at once. A regular request that is still pending after that sequence keeps waiting until the regular result is consumed.
- R10: With cfgAutoInj=1, every completed regular conversion starts the injected sequence automatically. With cfgAutoDelay=1 as well, no regular conversion starts while jeosFlag=1.
- R11: With cfgAutoDelay=0, a regular result that completes while eocFlag is still 1 sets the sticky ovrFlag. ovrFlag stays set until clrOvr. With cfgAutoDelay=1 it is never set.
- R12: While cfgDmaEn=1, each regular result pulses dmaReq for one cycle. With cfgDmaCirc=1 the pulses never stop. With cfgDmaCirc=0 they stop after cfgDmaLimit pulses, and deasserting cfgDmaEn restarts the count.
- R13: With cfgAutoDelay=0, there is no hold-off: a regular hardware trigger starts a conversion even while eocFlag=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgAutoDelay | input | 1 | Enable reader-paced hold-offs |
| cfgAutoInj | input | 1 | Injected sequence follows each regular result automatically |
| cfgInjLen | input | 2 | Injected sequence length minus one |
| cfgDmaEn | input | 1 | Enable DMA requests (low restarts the count) |
| cfgDmaCirc | input | 1 | 1: unlimited requests, 0: stop at cfgDmaLimit |
| cfgDmaLimit | input | 8 | Request count in one-shot mode |
| hwTrigReg | input | 1 | Regular hardware trigger pulse |
| hwTrigInj | input | 1 | Injected hardware trigger pulse |
| swStartReg | input | 1 | Regular software start pulse |
| swStartInj | input | 1 | Injected software start pulse |
| drRead | input | 1 | Data register read strobe |
| clrEoc | input | 1 | Clear end-of-conversion flag |
| clrJeos | input | 1 | Clear injected end-of-sequence flag |
| clrOvr | input | 1 | Clear overrun flag |
| convStart | output | 1 | One-cycle conversion start pulse |
| convGroup | output | 1 | Group of the started conversion (0 regular, 1 injected) |
| convChan | output | 2 | Injected sequence position of the started conversion |
| eocFlag | output | 1 | Regular result available |
| jeosFlag | output | 1 | Injected sequence complete |
| ovrFlag | output | 1 | Sticky regular overrun |
| dmaReq | output | 1 | One-cycle DMA request per regular result |

## Verification
The scheduler is driven with single regular triggers, triggers repeated while a result is still unread, triggers queued while a conversion is in flight, injected triggers mixed with regular hold-offs, and simultaneous requests for both groups. Comparing the order and group/channel tags of the start pulses against a predicted list shows whether a trigger was dropped, queued or given priority. Repeating the runs with hold-offs disabled, with auto-injection on, and with one-shot versus circular DMA separates behaviour that depends on the hold-off from behaviour that depends on priority or on counting.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic {
    GRP_REG = 1'b0,
    GRP_INJ = 1'b1
  } grp_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } sched_st_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic startReg;   // launch a regular conversion
    logic startInj;   // launch the first conversion of an injected sequence
    logic contInj;    // launch the next conversion inside an injected sequence
    logic running;    // a conversion is in flight
  } ctrl_strb_t;

endpackage

// File: rtl/sched_dpath.sv
module sched_dpath
  import sched_pkg::*;
#(
  parameter int CONV_CYCLES = 8,
  parameter int SEQ_MAX     = 4,
  parameter int DMA_W       = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrl_strb_t                 strb,
  input  logic                       cfgAutoDelay,
  input  logic [$clog2(SEQ_MAX)-1:0] cfgInjLen,
  input  logic                       cfgDmaEn,
  input  logic                       cfgDmaCirc,
  input  logic [DMA_W-1:0]           cfgDmaLimit,
  input  logic                       drRead,
  input  logic                       clrEoc,
  input  logic                       clrJeos,
  input  logic                       clrOvr,
  output logic                       convDone,
  output logic                       lastInj,
  output logic                       convStart,
  output logic                       convGroup,
  output logic [$clog2(SEQ_MAX)-1:0] convChan,
  output logic                       eocFlag,
  output logic                       jeosFlag,
  output logic                       ovrFlag,
  output logic                       dmaReq
);

  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam int IDX_W = $clog2(SEQ_MAX);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cntQ;
  logic [IDX_W-1:0] chanQ;
  logic             grpQ;
  logic             startQ;
  logic             eocQ, jeosQ, ovrQ;
  logic             dmaReqQ;
  logic [DMA_W-1:0] dmaCntQ;
  logic             anyStart;
  logic             regDone, injDone;
  logic             eocConsumed;
  logic             dmaIssue;

  assign anyStart    = strb.startReg | strb.startInj | strb.contInj;
  assign convDone    = strb.running && (cntQ == '0);
  assign regDone     = convDone && (grpQ == GRP_REG);
  assign injDone     = convDone && (grpQ == GRP_INJ);
  assign lastInj     = (chanQ == cfgInjLen);
  assign eocConsumed = drRead | clrEoc;
  assign dmaIssue    = regDone && cfgDmaEn && (cfgDmaCirc || (dmaCntQ < cfgDmaLimit));

  // Converter latency model
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (anyStart) begin
      cntQ <= CNT_LOAD;
    end else if (strb.running && cntQ != '0) begin
      cntQ <= cntQ - 1'b1;
    end
  end

  // Start pulse, group tag and sequence index
  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= 1'b0;
      grpQ   <= GRP_REG;
      chanQ  <= '0;
    end else begin
      startQ <= anyStart;
      if (strb.startReg) begin
        grpQ  <= GRP_REG;
        chanQ <= '0;
      end else if (strb.startInj) begin
        grpQ  <= GRP_INJ;
        chanQ <= '0;
      end else if (strb.contInj) begin
        chanQ <= chanQ + 1'b1;
      end
    end
  end

  // Result flags: a new result wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      eocQ  <= 1'b0;
      jeosQ <= 1'b0;
      ovrQ  <= 1'b0;
    end else begin
      if (regDone)          eocQ <= 1'b1;
      else if (eocConsumed) eocQ <= 1'b0;

      if (injDone && lastInj) jeosQ <= 1'b1;
      else if (clrJeos)       jeosQ <= 1'b0;

      if (regDone && !cfgAutoDelay && eocQ && !eocConsumed) ovrQ <= 1'b1;
      else if (clrOvr)                                        ovrQ <= 1'b0;
    end
  end

  // DMA request and one-shot count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmaReqQ <= 1'b0;
      dmaCntQ <= '0;
    end else begin
      dmaReqQ <= dmaIssue;
      if (!cfgDmaEn)     dmaCntQ <= '0;
      else if (dmaIssue) dmaCntQ <= dmaCntQ + 1'b1;
    end
  end

  assign convStart = startQ;
  assign convGroup = grpQ;
  assign convChan  = chanQ;
  assign eocFlag   = eocQ;
  assign jeosFlag  = jeosQ;
  assign ovrFlag   = ovrQ;
  assign dmaReq    = dmaReqQ;

  AST_EOC_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    regDone |=> eocQ); // R2
  AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (startQ && grpQ == GRP_INJ) |-> (chanQ <= cfgInjLen)); // R3
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovrQ && !clrOvr) |=> ovrQ); // R11
  AST_DMA_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (cfgDmaEn && !cfgDmaCirc && dmaCntQ >= cfgDmaLimit) |=> !dmaReqQ); // R12

endmodule

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import sched_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgAutoDelay,
  input  logic       cfgAutoInj,
  input  logic       hwTrigReg,
  input  logic       hwTrigInj,
  input  logic       swStartReg,
  input  logic       swStartInj,
  input  logic       eocFlag,
  input  logic       jeosFlag,
  input  logic       convDone,
  input  logic       lastInj,
  output ctrl_strb_t strb,
  output logic       idle
);

  sched_st_e stateQ;
  logic      curInjQ;
  logic      pendRegQ, regSwQ;
  logic      pendInjQ, injSwQ;
  logic      regHold, injHold, regGate;
  logic      goReg, goInj, fin, contInj, autoKick;

  assign regHold = cfgAutoDelay && eocFlag;
  assign injHold = cfgAutoDelay && jeosFlag;
  assign regGate = cfgAutoDelay && cfgAutoInj && jeosFlag;
  assign idle    = (stateQ == ST_IDLE);

  assign goInj    = idle && pendInjQ && (!injHold || injSwQ);
  assign goReg    = idle && !goInj && pendRegQ && (!regHold || regSwQ) && !regGate;
  assign fin      = (stateQ == ST_CONV) && convDone;
  assign contInj  = fin && curInjQ && !lastInj;
  assign autoKick = fin && !curInjQ && cfgAutoInj;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendRegQ <= 1'b0;
      regSwQ   <= 1'b0;
      pendInjQ <= 1'b0;
      injSwQ   <= 1'b0;
    end else begin
      pendRegQ <= (pendRegQ && !goReg) || (hwTrigReg && !regHold) || swStartReg;
      regSwQ   <= (regSwQ && !goReg) || swStartReg;
      pendInjQ <= (pendInjQ && !goInj) || (hwTrigInj && !injHold) || swStartInj || autoKick;
      injSwQ   <= (injSwQ && !goInj) || swStartInj;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      curInjQ <= 1'b0;
    end else begin
      if (goInj)      curInjQ <= 1'b1;
      else if (goReg) curInjQ <= 1'b0;
      unique case (stateQ)
        ST_IDLE: if (goInj || goReg) stateQ <= ST_CONV;
        ST_CONV: if (fin && !contInj) stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.startReg = goReg;
    strb.startInj = goInj;
    strb.contInj  = contInj;
    strb.running  = (stateQ == ST_CONV);
  end

  AST_HW_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAutoDelay && eocFlag && hwTrigReg && !pendRegQ && !swStartReg) |=> !pendRegQ); // R5
  AST_INJ_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (idle && pendInjQ && pendRegQ && !injHold) |=> curInjQ); // R4

endmodule

// File: rtl/adc_sched.sv
module adc_sched
  import sched_pkg::*;
#(
  parameter int CONV_CYCLES = 8,
  parameter int SEQ_MAX     = 4,
  parameter int DMA_W       = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgAutoDelay,
  input  logic         cfgAutoInj,
  input  logic [1:0]   cfgInjLen,
  input  logic         cfgDmaEn,
  input  logic         cfgDmaCirc,
  input  logic [7:0]   cfgDmaLimit,
  input  logic         hwTrigReg,
  input  logic         hwTrigInj,
  input  logic         swStartReg,
  input  logic         swStartInj,
  input  logic         drRead,
  input  logic         clrEoc,
  input  logic         clrJeos,
  input  logic         clrOvr,
  output logic         convStart,
  output logic         convGroup,
  output logic [1:0]   convChan,
  output logic         eocFlag,
  output logic         jeosFlag,
  output logic         ovrFlag,
  output logic         dmaReq
);

  localparam int IDX_W = $clog2(SEQ_MAX);

  ctrl_strb_t strb;
  logic       convDone;
  logic       lastInj;
  logic       idle;
  logic [IDX_W-1:0] chanW;

  sched_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgAutoDelay (cfgAutoDelay),
    .cfgAutoInj   (cfgAutoInj),
    .hwTrigReg    (hwTrigReg),
    .hwTrigInj    (hwTrigInj),
    .swStartReg   (swStartReg),
    .swStartInj   (swStartInj),
    .eocFlag      (eocFlag),
    .jeosFlag     (jeosFlag),
    .convDone     (convDone),
    .lastInj      (lastInj),
    .strb         (strb),
    .idle         (idle)
  );

  sched_dpath #(
    .CONV_CYCLES (CONV_CYCLES),
    .SEQ_MAX     (SEQ_MAX),
    .DMA_W       (DMA_W)
  ) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .cfgAutoDelay (cfgAutoDelay),
    .cfgInjLen    (IDX_W'(cfgInjLen)),
    .cfgDmaEn     (cfgDmaEn),
    .cfgDmaCirc   (cfgDmaCirc),
    .cfgDmaLimit  (DMA_W'(cfgDmaLimit)),
    .drRead       (drRead),
    .clrEoc       (clrEoc),
    .clrJeos      (clrJeos),
    .clrOvr       (clrOvr),
    .convDone     (convDone),
    .lastInj      (lastInj),
    .convStart    (convStart),
    .convGroup    (convGroup),
    .convChan     (chanW),
    .eocFlag      (eocFlag),
    .jeosFlag     (jeosFlag),
    .ovrFlag      (ovrFlag),
    .dmaReq       (dmaReq)
  );

  assign convChan = 2'(chanW);

  AST_AUTOINJ_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (idle && cfgAutoDelay && cfgAutoInj && jeosFlag) |=> !(convStart && convGroup == GRP_REG)); // R10

endmodule

// File: tb/tb_adc_sched.sv
module tb_adc_sched;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cfgAutoDelay, cfgAutoInj, cfgDmaEn, cfgDmaCirc;
  logic [1:0] cfgInjLen;
  logic [7:0] cfgDmaLimit;
  logic       hwTrigReg, hwTrigInj, swStartReg, swStartInj;
  logic       drRead, clrEoc, clrJeos, clrOvr;
  logic       convStart, convGroup, eocFlag, jeosFlag, ovrFlag, dmaReq;
  logic [1:0] convChan;

  typedef struct {
    logic       grp;
    logic [1:0] chan;
    string      tag;
  } exp_t;

  exp_t  expQ[$];
  string curReq = "R1";
  int    total = 0;
  int    bad = 0;
  int    dmaSeen = 0;
  bit    finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  adc_sched dut (
    .clk(clk), .rstN(rstN), .cfgAutoDelay(cfgAutoDelay), .cfgAutoInj(cfgAutoInj),
    .cfgInjLen(cfgInjLen), .cfgDmaEn(cfgDmaEn), .cfgDmaCirc(cfgDmaCirc),
    .cfgDmaLimit(cfgDmaLimit), .hwTrigReg(hwTrigReg), .hwTrigInj(hwTrigInj),
    .swStartReg(swStartReg), .swStartInj(swStartInj), .drRead(drRead),
    .clrEoc(clrEoc), .clrJeos(clrJeos), .clrOvr(clrOvr), .convStart(convStart),
    .convGroup(convGroup), .convChan(convChan), .eocFlag(eocFlag),
    .jeosFlag(jeosFlag), .ovrFlag(ovrFlag), .dmaReq(dmaReq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_conv(input logic grp, input logic [1:0] chan, input string tag);
    exp_t e;
    e.grp = grp; e.chan = chan; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic expect_inj_seq(input string tag);
    for (int i = 0; i <= 2; i++) expect_conv(1'b1, 2'(i), tag);
  endtask

  // Scoreboard monitor: compares every start pulse with the predicted list
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (dmaReq) dmaSeen++;
      if (convStart) begin
        total++;
        if (expQ.size() == 0) begin
          bad++;
          $display("FAIL %s: actual=unexpected start grp%0d ch%0d expected=no start",
                   curReq, convGroup, convChan);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          if (convGroup !== e.grp || convChan !== e.chan) begin
            bad++;
            $display("FAIL %s: actual=grp%0d ch%0d expected=grp%0d ch%0d",
                     e.tag, convGroup, convChan, e.grp, e.chan);
          end
        end
      end
    end
  end

  // sel: 0 hwReg 1 hwInj 2 swReg 3 swInj 4 drRead 5 clrEoc 6 clrJeos 7 clrOvr
  task automatic pulse(input int sel);
    @(posedge clk); #1;
    case (sel)
      0: hwTrigReg = 1'b1;
      1: hwTrigInj = 1'b1;
      2: swStartReg = 1'b1;
      3: swStartInj = 1'b1;
      4: drRead = 1'b1;
      5: clrEoc = 1'b1;
      6: clrJeos = 1'b1;
      default: clrOvr = 1'b1;
    endcase
    @(posedge clk); #1;
    hwTrigReg = 0; hwTrigInj = 0; swStartReg = 0; swStartInj = 0;
    drRead = 0; clrEoc = 0; clrJeos = 0; clrOvr = 0;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drain(input string req);
    check({req, " pending expected starts"}, expQ.size(), 0);
    expQ.delete();
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 0;
    cfgAutoDelay = 1; cfgAutoInj = 0; cfgInjLen = 2'd2;
    cfgDmaEn = 1; cfgDmaCirc = 1; cfgDmaLimit = 8'd2;
    hwTrigReg = 0; hwTrigInj = 0; swStartReg = 0; swStartInj = 0;
    drRead = 0; clrEoc = 0; clrJeos = 0; clrOvr = 0;
    waitc(4);
    rstN = 1;
    waitc(1);

    // R1 reset state
    curReq = "R1";
    check("R1 convStart", convStart, 0);
    check("R1 eocFlag", eocFlag, 0);
    check("R1 jeosFlag", jeosFlag, 0);
    check("R1 ovrFlag", ovrFlag, 0);
    check("R1 dmaReq", dmaReq, 0);
    waitc(20);

    // R2 basic regular conversion
    curReq = "R2";
    expect_conv(0, 0, "R2");
    pulse(0);
    waitc(20);
    check("R2 eocFlag", eocFlag, 1);
    drain("R2");

    // R5 trigger during hold is dropped, and not replayed after the read
    curReq = "R5";
    pulse(0);
    waitc(20);
    check("R5 eocFlag still set", eocFlag, 1);
    pulse(4);
    waitc(20);
    check("R5 eocFlag cleared by read", eocFlag, 0);

    // R6 hold ended by read (already) and by flag clear
    curReq = "R6";
    expect_conv(0, 0, "R6");
    pulse(0);
    waitc(20);
    pulse(5);
    expect_conv(0, 0, "R6");
    pulse(0);
    waitc(20);
    check("R6 eocFlag", eocFlag, 1);
    drain("R6");

    // R8 software start bypasses the hold
    curReq = "R8";
    expect_conv(0, 0, "R8");
    pulse(2);
    waitc(20);
    drain("R8");

    // R9 / R3 injected sequence starts during regular hold
    curReq = "R3";
    expect_inj_seq("R9 R3");
    pulse(1);
    waitc(40);
    check("R3 jeosFlag after sequence", jeosFlag, 1);
    drain("R3");

    // R7 injected trigger dropped while jeos set, accepted after clear
    curReq = "R7";
    pulse(1);
    waitc(40);
    pulse(6);
    expect_inj_seq("R7 R3");
    pulse(1);
    waitc(40);
    drain("R7");

    // R4 simultaneous requests: injected first
    curReq = "R4";
    pulse(6);
    pulse(4);
    waitc(4);
    expect_inj_seq("R4");
    expect_conv(0, 0, "R4");
    @(posedge clk); #1;
    hwTrigReg = 1; hwTrigInj = 1;
    @(posedge clk); #1;
    hwTrigReg = 0; hwTrigInj = 0;
    waitc(60);
    drain("R4");
    pulse(6);
    pulse(4);

    // R9 queued regular waits for its hold across an injected sequence
    curReq = "R9";
    expect_conv(0, 0, "R9");
    pulse(0);
    waitc(2);
    pulse(0);
    waitc(20);
    check("R9 eocFlag", eocFlag, 1);
    expect_inj_seq("R9");
    pulse(1);
    waitc(50);
    drain("R9");
    expect_conv(0, 0, "R9");
    pulse(4);
    waitc(20);
    drain("R9");
    pulse(6);
    pulse(4);

    // R12 circular DMA: every regular result so far (7), beyond the limit of 2
    check("R12 circular dma count", dmaSeen, 7);
    check("R11 no overrun with auto-delay", ovrFlag, 0);

    // R12 one-shot DMA stops at the limit
    curReq = "R12";
    cfgDmaEn = 0;
    waitc(2);
    cfgDmaCirc = 0; cfgDmaEn = 1;
    dmaSeen = 0;
    for (int k = 0; k < 3; k++) begin
      expect_conv(0, 0, "R12");
      pulse(2);
      waitc(20);
    end
    check("R12 one-shot dma count", dmaSeen, 2);
    drain("R12");

    // R10 auto-injected mode
    curReq = "R10";
    cfgAutoInj = 1;
    pulse(4);
    pulse(6);
    waitc(2);
    expect_conv(0, 0, "R10");
    expect_inj_seq("R10");
    pulse(0);
    waitc(60);
    check("R10 jeosFlag", jeosFlag, 1);
    drain("R10");
    pulse(4);
    waitc(2);
    pulse(0);
    waitc(30);
    expect_conv(0, 0, "R10");
    expect_inj_seq("R10");
    pulse(6);
    waitc(60);
    drain("R10");
    cfgAutoInj = 0;
    pulse(6);
    pulse(4);
    waitc(4);

    // R13 / R11 no hold-off without auto-delay, overrun set
    curReq = "R13";
    cfgAutoDelay = 0;
    check("R11 ovrFlag before", ovrFlag, 0);
    expect_conv(0, 0, "R13");
    pulse(0);
    waitc(20);
    check("R13 eocFlag", eocFlag, 1);
    expect_conv(0, 0, "R13");
    pulse(0);
    waitc(20);
    drain("R13");
    check("R11 ovrFlag set", ovrFlag, 1);
    waitc(5);
    check("R11 ovrFlag sticky", ovrFlag, 1);
    pulse(7);
    waitc(1);
    check("R11 ovrFlag cleared", ovrFlag, 0);

    waitc(5);
    drain("final");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule